// File: doc/BRIEF.md
# Stereo Serial Word Placer

This block sends one stereo sample pair per frame out on a single serial data line, most significant bit first. A bit clock and a left/right select come in as levels and are sampled by the system clock. The output changes only when a falling bit-clock edge is seen, so a receiver can capture it on the following rising edge. The left word goes out while the left/right select is low and the right word while it is high. A frame begins at the first low field after a high one.

In the long-frame mode each field lasts 32 bit slots, and a placement strobe decides where the word starts. The strobe is sampled at each falling edge. When it is first seen high in slot s, the MSB goes out in slot s+1. A high strobe in slot 1 therefore gives the one-bit-delayed layout used by I2S. A strobe timed so that the word ends in slot 32 gives a right-justified layout. Each field makes this choice on its own, so one frame can hold both layouts. In the short-frame mode each field carries the upper 16 bits of the word from slot 1, and the strobe plays no part. Every slot not carrying a data bit is driven low.

Top module: `aud_field_formatter`

## Requirements
- R1: While reset is asserted and right after it is released, `sdata` is 0.
- R2: A field begins at each falling bit-clock edge where the sampled `lrck` differs from its value at the previous falling edge. The field with `lrck` = 0 carries `left_in` and the field with `lrck` = 1 carries `right_in`.
- R3: In the long-frame mode (`mode64` = 1), a strobe seen high in slot 1 of a field puts the MSB in slot 2. Slot 1 is then 0.
- R4: In the long-frame mode, when the strobe is first seen high in slot s, the MSB goes out in slot s+1. With s = 14 for 18-bit words, or s = 12 for 20-bit words, the LSB falls in slot 32.
- R5: Every slot of a long-frame field before the MSB or after the LSB is 0. A field in which the strobe is never high is all zeros.
- R6: The placement is decided separately for the left field and the right field of the same frame.
- R7: With `len18` = 1 the word is `port[19:2]`, 18 bits long, and `port[1:0]` never appears. With `len18` = 0 the word is all 20 bits. Exactly that many bits are sent after the start.
- R8: Once a word has started, further strobe pulses in the same field have no effect.
- R9: In the short-frame mode (`mode64` = 0), slots 1 to 16 of a field carry `port[19:4]`, MSB first, and the strobe is ignored.
- R10: Both words are taken at the start of the left field. Changes to `left_in` or `right_in` after that point appear only in the next frame.
- R11: `sdata` changes only on a clock cycle in which a falling bit-clock edge is detected.
- R12: A word started too late to fit is cut off at the field boundary. The next field starts clean.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial clocks |
| rst_n | input | 1 | Asynchronous active-low reset |
| bck | input | 1 | Bit clock level |
| lrck | input | 1 | Left/right field select level |
| wck | input | 1 | Placement strobe for the long-frame mode |
| mode64 | input | 1 | 1: 32-slot fields; 0: 16-slot fields |
| len18 | input | 1 | 1: 18-bit words; 0: 20-bit words |
| left_in | input | 20 | Left sample, MSB-aligned |
| right_in | input | 20 | Right sample, MSB-aligned |
| sdata | output | 1 | Serial data out |

## Verification
The hardest case to reach is a field whose word is already running, or already finished, when the strobe pulses again, together with a late start that runs past the field boundary. Both depend on strobe timing measured in slots rather than clock cycles. The bench therefore drives the strobe slot by slot, with a pulse at a chosen start slot and a second pulse placed either inside the word or after it. It also starts one word in slot 26, so that it is cut off, and follows it with a field that starts in slot 1. To show that the pair is held for the whole frame, the input words are changed just after the first slot of every frame.

// File: rtl/sfmt_pkg.sv
package sfmt_pkg;
  localparam int unsigned PORT_W   = 20;
  localparam int unsigned SHORT_W  = 18;
  localparam int unsigned NARROW_W = 16;

  // Slot action passed from the sequencer to the shifter.
  typedef enum logic [1:0] {
    CTL_IDLE       = 2'd0,
    CTL_LOAD_ZERO  = 2'd1,
    CTL_LOAD_SHIFT = 2'd2,
    CTL_SHIFT      = 2'd3
  } slot_ctl_e;
endpackage

// File: rtl/sfmt_edge.sv
module sfmt_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic bck,
  input  logic lrck,
  output logic fall,
  output logic new_field,
  output logic left_start
);
  logic bck_q, lr_q, lr_d;

  assign fall       = bck_q & ~bck;
  assign new_field  = fall & (lrck != lr_q);
  assign left_start = new_field & ~lrck;

  always_comb begin
    lr_d = lr_q;
    if (fall) lr_d = lrck;
  end

  // lr_q starts high so the first low field opens a frame.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bck_q <= 1'b0;
      lr_q  <= 1'b1;
    end else begin
      bck_q <= bck;
      lr_q  <= lr_d;
    end
  end
endmodule

// File: rtl/sfmt_seq.sv
module sfmt_seq
  import sfmt_pkg::*;
#(
  parameter int unsigned WORD_W   = PORT_W,
  parameter int unsigned SHORT_LEN = SHORT_W,
  parameter int unsigned NARROW_LEN = NARROW_W
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      fall,
  input  logic      new_field,
  input  logic      wck,
  input  logic      mode64,
  input  logic      len18,
  output slot_ctl_e ctl
);
  localparam int unsigned CNT_W = $clog2(WORD_W);

  logic             pending, pending_d;
  logic             used, used_d;
  logic [CNT_W-1:0] remain, remain_d;

  always_comb begin
    pending_d = pending;
    used_d    = used;
    remain_d  = remain;
    ctl       = CTL_IDLE;
    if (fall) begin
      if (new_field) begin
        used_d = 1'b0;
        if (mode64) begin
          pending_d = wck;
          remain_d  = '0;
          ctl       = CTL_LOAD_ZERO;
        end else begin
          pending_d = 1'b0;
          remain_d  = CNT_W'(NARROW_LEN - 1);
          ctl       = CTL_LOAD_SHIFT;
        end
      end else if (pending) begin
        ctl       = CTL_SHIFT;
        pending_d = 1'b0;
        used_d    = 1'b1;
        remain_d  = len18 ? CNT_W'(SHORT_LEN - 1) : CNT_W'(WORD_W - 1);
      end else if (remain != '0) begin
        ctl      = CTL_SHIFT;
        remain_d = remain - 1'b1;
      end else if (mode64 && !used && wck) begin
        pending_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending <= 1'b0;
      used    <= 1'b0;
      remain  <= '0;
    end else begin
      pending <= pending_d;
      used    <= used_d;
      remain  <= remain_d;
    end
  end

  p_remain_max_r7: assert property (@(posedge clk) disable iff (!rst_n)
    remain <= CNT_W'(WORD_W - 1));
  p_start_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fall && !new_field && pending |=>
      used && (remain == ($past(len18) ? CNT_W'(SHORT_LEN - 1) : CNT_W'(WORD_W - 1))));
  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fall && !new_field && used |=> !pending);
  p_narrow_nostrobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fall && new_field && !mode64 |=> !pending && !used);
endmodule

// File: rtl/sfmt_shifter.sv
module sfmt_shifter
  import sfmt_pkg::*;
#(
  parameter int unsigned WORD_W    = PORT_W,
  parameter int unsigned SHORT_LEN = SHORT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fall,
  input  logic              left_start,
  input  slot_ctl_e         ctl,
  input  logic              len18,
  input  logic [WORD_W-1:0] left_in,
  input  logic [WORD_W-1:0] right_in,
  output logic              sdata
);
  localparam logic [WORD_W-1:0] SHORT_MASK =
    {{SHORT_LEN{1'b1}}, {(WORD_W - SHORT_LEN){1'b0}}};

  logic [WORD_W-1:0] shreg, shreg_d;
  logic [WORD_W-1:0] hold_r, hold_d;
  logic [WORD_W-1:0] word_sel;
  logic              sdata_d;

  // Left word enters straight from the port; right word waits in hold_r.
  always_comb begin
    word_sel = left_start ? left_in : hold_r;
    if (len18) word_sel = word_sel & SHORT_MASK;
  end

  always_comb begin
    hold_d  = hold_r;
    shreg_d = shreg;
    sdata_d = sdata;
    if (left_start) hold_d = right_in;
    unique case (ctl)
      CTL_LOAD_ZERO: begin
        shreg_d = word_sel;
        sdata_d = 1'b0;
      end
      CTL_LOAD_SHIFT: begin
        sdata_d = word_sel[WORD_W-1];
        shreg_d = {word_sel[WORD_W-2:0], 1'b0};
      end
      CTL_SHIFT: begin
        sdata_d = shreg[WORD_W-1];
        shreg_d = {shreg[WORD_W-2:0], 1'b0};
      end
      default: if (fall) sdata_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg  <= '0;
      hold_r <= '0;
      sdata  <= 1'b0;
    end else begin
      shreg  <= shreg_d;
      hold_r <= hold_d;
      sdata  <= sdata_d;
    end
  end

  p_edge_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fall |=> $stable(sdata));
  p_right_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !left_start |=> $stable(hold_r));
endmodule

// File: rtl/aud_field_formatter.sv
module aud_field_formatter
  import sfmt_pkg::*;
#(
  parameter int unsigned WORD_W     = PORT_W,
  parameter int unsigned SHORT_LEN  = SHORT_W,
  parameter int unsigned NARROW_LEN = NARROW_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bck,
  input  logic              lrck,
  input  logic              wck,
  input  logic              mode64,
  input  logic              len18,
  input  logic [WORD_W-1:0] left_in,
  input  logic [WORD_W-1:0] right_in,
  output logic              sdata
);
  logic [1:0] rst_pipe;
  logic       rst_q;
  logic       fall, new_field, left_start;
  slot_ctl_e  ctl;

  // Assert at once, release two clocks later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  sfmt_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_q),
    .bck        (bck),
    .lrck       (lrck),
    .fall       (fall),
    .new_field  (new_field),
    .left_start (left_start)
  );

  sfmt_seq #(
    .WORD_W     (WORD_W),
    .SHORT_LEN  (SHORT_LEN),
    .NARROW_LEN (NARROW_LEN)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_q),
    .fall      (fall),
    .new_field (new_field),
    .wck       (wck),
    .mode64    (mode64),
    .len18     (len18),
    .ctl       (ctl)
  );

  sfmt_shifter #(
    .WORD_W    (WORD_W),
    .SHORT_LEN (SHORT_LEN)
  ) u_shift (
    .clk        (clk),
    .rst_n      (rst_q),
    .fall       (fall),
    .left_start (left_start),
    .ctl        (ctl),
    .len18      (len18),
    .left_in    (left_in),
    .right_in   (right_in),
    .sdata      (sdata)
  );

  p_lead_zero_r5: assert property (@(posedge clk) disable iff (!rst_q)
    fall && new_field && mode64 |=> !sdata);
  p_reset_low_r1: assert property (@(posedge clk)
    !rst_q |=> !sdata);
endmodule

// File: tb/aud_field_formatter_bench.sv
module aud_field_formatter_bench;
  logic        clk, rst_n, bck, lrck, wck, mode64, len18, sdata;
  logic [19:0] left_in, right_in;
  int tests, fails, r11_bad;
  bit done;

  aud_field_formatter u_aud_field_formatter (
    .clk(clk), .rst_n(rst_n), .bck(bck), .lrck(lrck), .wck(wck),
    .mode64(mode64), .len18(len18), .left_in(left_in),
    .right_in(right_in), .sdata(sdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [31:0] exp_field(input logic [19:0] w, input logic m64,
                                            input logic l18, input int s);
    logic [31:0] v;
    int wl;
    v  = '0;
    wl = l18 ? 18 : 20;
    if (!m64) begin
      for (int k = 1; k <= 16; k++) v[32-k] = w[20-k];
    end else if (s != 0) begin
      for (int k = s + 1; k <= 32; k++)
        if (k <= s + wl) v[32-k] = w[19-(k-s-1)];
    end
    return v;
  endfunction

  task automatic check_vec(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic slot(input logic lr, input logic w, output logic b);
    @(negedge clk); bck = 1'b0; lrck = lr; wck = w;
    @(negedge clk); b = sdata;
    @(negedge clk); bck = 1'b1;
    @(negedge clk); if (sdata !== b) r11_bad++;
  endtask

  // Runs one field; the strobe pulses in slots s and x (0 means none).
  task automatic run_field(input logic lr, input logic [19:0] w, input int s, input int x,
                           input string tag);
    logic [31:0] got;
    logic b;
    int n;
    got = '0;
    n = mode64 ? 32 : 16;
    for (int k = 1; k <= n; k++) begin
      slot(lr, (s != 0 && k == s) || (x != 0 && k == x), b);
      got[32-k] = b;
      if (!lr && k == 1) begin
        left_in  = left_in ^ 20'hA5C3F;
        right_in = ~right_in;
      end
    end
    check_vec(tag, got, exp_field(w, mode64, len18, s));
  endtask

  task automatic run_frame(input logic [19:0] l, input logic [19:0] r,
                           input int sl, input int xl, input int sr, input int xr,
                           input string tag_l, input string tag_r);
    left_in = l; right_in = r;
    run_field(1'b0, l, sl, xl, tag_l);
    run_field(1'b1, r, sr, xr, tag_r);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; bck = 1'b1; lrck = 1'b1; wck = 1'b0;
    mode64 = 1'b1; len18 = 1'b0; left_in = '0; right_in = '0;
    repeat (4) @(negedge clk);
    tests++;
    if (sdata !== 1'b0) begin fails++; $display("FAIL R1 in reset: got %b expected 0", sdata); end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    tests++;
    if (sdata !== 1'b0) begin fails++; $display("FAIL R1 after release: got %b expected 0", sdata); end
  endtask

  task automatic t_i2s;
    mode64 = 1'b1; len18 = 1'b0;
    run_frame(20'hB3C5A, 20'h4E1D7, 1, 0, 1, 0, "R3 R2 left slot2 MSB", "R3 R2 right slot2 MSB");
  endtask

  task automatic t_right_just;
    mode64 = 1'b1; len18 = 1'b1;
    run_frame(20'hF0F3B, 20'h9ACE7, 14, 0, 14, 0, "R4 R7 left 18-bit", "R4 R7 right 18-bit");
    len18 = 1'b0;
    run_frame(20'h8765D, 20'h13579, 12, 0, 12, 0, "R4 left 20-bit", "R4 right 20-bit");
  endtask

  task automatic t_mixed;
    mode64 = 1'b1; len18 = 1'b1;
    run_frame(20'hD2B4F, 20'hC6E2B, 14, 0, 1, 0, "R6 left right-justified", "R6 right I2S");
  endtask

  task automatic t_zero_fill;
    mode64 = 1'b1; len18 = 1'b0;
    run_frame(20'hFFFFF, 20'hFFFFF, 0, 0, 5, 0, "R5 no strobe all zero", "R5 zeros around word");
  endtask

  task automatic t_ignore;
    mode64 = 1'b1; len18 = 1'b0;
    run_frame(20'hA1B2C, 20'h5D6E7, 2, 10, 2, 25, "R8 pulse inside word", "R8 pulse after word");
  endtask

  task automatic t_late;
    mode64 = 1'b1; len18 = 1'b0;
    run_frame(20'hE9F1D, 20'h7B3C5, 25, 0, 1, 0, "R12 truncated word", "R12 clean next field");
  endtask

  task automatic t_narrow;
    mode64 = 1'b0; len18 = 1'b0;
    run_frame(20'h9C3A5, 20'h36E1F, 1, 5, 3, 0, "R9 left top16", "R9 right top16");
    len18 = 1'b1;
    run_frame(20'h5AC3B, 20'hE47D2, 0, 0, 2, 0, "R9 left top16 short", "R9 right top16 short");
  endtask

  task automatic t_latch;
    // run_frame alters both inputs after slot 1; the right field must keep the old word.
    mode64 = 1'b1; len18 = 1'b0;
    run_frame(20'h0F1E2, 20'hC0DE5, 3, 0, 3, 0, "R10 left first pair", "R10 right held word");
    run_frame(20'h77A19, 20'h2B8F4, 1, 0, 1, 0, "R10 left new pair", "R10 right new pair");
  endtask

  initial begin
    tests = 0; fails = 0; r11_bad = 0; done = 1'b0;
    t_reset();
    t_i2s();
    t_right_just();
    t_mixed();
    t_zero_fill();
    t_ignore();
    t_late();
    t_narrow();
    t_latch();
    tests++;
    if (r11_bad != 0) begin
      fails++;
      $display("FAIL R11 output moved within a slot: got %0d changes expected 0", r11_bad);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule